// File: doc/BRIEF.md
# LPDDR Power-Up Initialization Sequencer

This block is the controller-side state machine that walks an LPDDR-class DRAM from power-on to its first usable state. It drives the memory reset line and, for each sub-channel, chip select, the command/address bus, a CK enable, a WCK enable and a DQ output enable. Every required delay is held as a picosecond parameter. It is turned into a count of controller clock cycles at elaboration, rounded up. The memory CK is taken to run at the controller clock rate.

Software or a boot controller pulses `start_i` with a sub-channel count of one or two. The sequencer then holds the memory in reset until the supplies are reported good. It walks through the ordered windows: reset hold, chip-select setup, chip-select hold after reset release and CK stabilisation. It then issues a NOP, waits, and issues a mode-register write, a mode-register read and a ZQ calibration latch, each with a placeholder CA code. After the ZQ latch wait it enables WCK and reports done. When two sub-channels are selected, both are driven in lockstep.

Top module: `lpinit_seq`

## Requirements
- R1: After reset, `mem_reset_n_o` is 0, and `cs_o`, `ca_o`, `ck_en_o`, `wck_en_o`, `busy_o`, `done_o` and `err_o` are all 0.
- R2: A `start_i` pulse seen while not busy, with `ch_cnt_i` of 1 or 2, raises `busy_o` in the next cycle. The block then holds `mem_reset_n_o` low for as long as `supply_ok_i` is low.
- R3: Counting from the first clock edge that samples `supply_ok_i` high, reset stays low for N_RST = ceil(T_RST_PS/CLK_PERIOD_PS) cycles and then for N_CSPRE = ceil(T_CSPRE_PS/CLK_PERIOD_PS) more cycles, with chip select low throughout. After that `mem_reset_n_o` and the CK enable rise in the same cycle.
- R4: After `mem_reset_n_o` rises, chip select stays low for N_CSHOLD = ceil(T_CSHOLD_PS/CLK_PERIOD_PS) plus CK_STABLE_CYC cycles.
- R5: The first command is a NOP. Chip select is high for CMD_CYC cycles with CA equal to CA_NOP. Then chip select and CA are 0 for one cycle.
- R6: After the NOP comes a wait of ceil(T_MRWAIT_PS/CLK_PERIOD_PS) cycles, then three back-to-back commands shaped as in R5: CA_MRW, then CA_MRR, then CA_ZQ.
- R7: After the ZQ command comes a wait of max(ceil(T_ZQ_PS/CLK_PERIOD_PS), ZQ_MIN_CK) cycles. Then `busy_o` falls, `done_o` rises, and the WCK enables of the active sub-channels rise in the same cycle. WCK is never enabled before done.
- R8: With `ch_cnt_i` = 2, sub-channels 0 and 1 carry identical chip select, CA (sub-channel i on `ca_o[i*CA_W +: CA_W]`), CK enable and WCK enable in every cycle. With `ch_cnt_i` = 1, sub-channel 1 stays all zero.
- R9: A start with `ch_cnt_i` of 0 or 3 sets `err_o` without `busy_o`, and the memory-side outputs return to the R1 state.
- R10: A `start_i` pulse while `busy_o` is 1 is ignored: the sequence, its channel count and its timing continue unchanged.
- R11: `done_o` and `err_o` stay set until the next accepted start, and at most one of `busy_o`, `done_o` and `err_o` is 1.
- R12: `dq_oe_o` is 0 in every cycle, so DQ stays tri-stated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| supply_ok_i | input | 1 | Supplies reported stable |
| ch_cnt_i | input | $clog2(MAX_CH+1) | Number of sub-channels to drive (1 or 2) |
| mem_reset_n_o | output | 1 | Memory reset, active low |
| cs_o | output | MAX_CH | Chip select per sub-channel |
| ca_o | output | MAX_CH*CA_W | Command/address per sub-channel |
| ck_en_o | output | MAX_CH | CK toggle enable per sub-channel |
| wck_en_o | output | MAX_CH | WCK toggle enable per sub-channel |
| dq_oe_o | output | MAX_CH | DQ output enable per sub-channel |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished (sticky) |
| err_o | output | 1 | Invalid channel count (sticky) |

## Verification
The bench builds the sequencer with a 5000 ps clock and shortened windows: reset hold 40 ns, CS setup 10 ns, CS hold 30 ns, mode-register wait 12 ns and ZQ wait 12 ns. The whole sequence then fits in about forty cycles, so every phase boundary is compared cycle by cycle. The 12 ns values give a fractional cycle count, which exercises the rounding up. The ZQ value falls below the four-cycle floor, so the floor is what sets that window. Runs cover one sub-channel and two sub-channels, a supply that arrives late, a start pulse while busy, and both invalid counts.

// File: rtl/lpinit_pkg.sv
package lpinit_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WSUP,
    ST_RHOLD,
    ST_CSPRE,
    ST_CSHOLD,
    ST_CKSTAB,
    ST_NOP,
    ST_MRWAIT,
    ST_MRW,
    ST_MRR,
    ST_ZQ,
    ST_ZQWAIT,
    ST_DONE,
    ST_ERR
  } seq_st_e;

  // Delay in ps to whole cycles, rounded up, never below one.
  function automatic longint unsigned ps2cyc(input longint unsigned dly_ps,
                                             input longint unsigned per_ps);
    longint unsigned q;
    q = (dly_ps + per_ps - 1) / per_ps;
    return (q == 0) ? 64'd1 : q;
  endfunction

  function automatic longint unsigned max64(input longint unsigned a,
                                            input longint unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lpinit_rstsync.sv
module lpinit_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/lpinit_timer.sv
module lpinit_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic [TW-1:0] ld_val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (ld_i) begin
      cnt_en = 1'b1;
      cnt_d  = ld_val_i;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/lpinit_fsm.sv
module lpinit_fsm
  import lpinit_pkg::*;
#(
  parameter int            TW       = 8,
  parameter int            MAX_CH   = 2,
  parameter int            CW       = 2,
  parameter logic [TW-1:0] D_RST    = '0,
  parameter logic [TW-1:0] D_CSPRE  = '0,
  parameter logic [TW-1:0] D_CSHOLD = '0,
  parameter logic [TW-1:0] D_CKSTAB = '0,
  parameter logic [TW-1:0] D_MRWAIT = '0,
  parameter logic [TW-1:0] D_ZQWAIT = '0,
  parameter logic [TW-1:0] D_CMD    = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              supply_ok_i,
  input  logic [CW-1:0]     ch_cnt_i,
  input  logic              tmr_zero_i,
  output seq_st_e           st_o,
  output logic              tmr_ld_o,
  output logic [TW-1:0]     tmr_val_o,
  output logic [MAX_CH-1:0] mask_o
);
  seq_st_e           st_q, st_d;
  logic [MAX_CH-1:0] mask_q, mask_d;
  logic              mask_en;
  logic              cnt_ok;

  // Last cycle index (duration minus one) of each timed phase.
  function automatic logic [TW-1:0] last_idx(input seq_st_e s);
    case (s)
      ST_RHOLD:                 return D_RST;
      ST_CSPRE:                 return D_CSPRE;
      ST_CSHOLD:                return D_CSHOLD;
      ST_CKSTAB:                return D_CKSTAB;
      ST_MRWAIT:                return D_MRWAIT;
      ST_ZQWAIT:                return D_ZQWAIT;
      ST_NOP, ST_MRW, ST_MRR,
      ST_ZQ:                    return D_CMD;
      default:                  return '0;
    endcase
  endfunction

  function automatic seq_st_e succ(input seq_st_e s);
    case (s)
      ST_RHOLD:  return ST_CSPRE;
      ST_CSPRE:  return ST_CSHOLD;
      ST_CSHOLD: return ST_CKSTAB;
      ST_CKSTAB: return ST_NOP;
      ST_NOP:    return ST_MRWAIT;
      ST_MRWAIT: return ST_MRW;
      ST_MRW:    return ST_MRR;
      ST_MRR:    return ST_ZQ;
      ST_ZQ:     return ST_ZQWAIT;
      default:   return ST_DONE;
    endcase
  endfunction

  assign cnt_ok = (int'(ch_cnt_i) >= 1) && (int'(ch_cnt_i) <= MAX_CH);

  always_comb begin
    for (int i = 0; i < MAX_CH; i++) begin
      mask_d[i] = (int'(ch_cnt_i) > i);
    end
  end

  always_comb begin
    st_d    = st_q;
    mask_en = 1'b0;
    case (st_q)
      ST_IDLE, ST_DONE, ST_ERR: begin
        if (start_i) begin
          if (cnt_ok) begin
            st_d    = ST_WSUP;
            mask_en = 1'b1;
          end else begin
            st_d    = ST_ERR;
          end
        end
      end
      ST_WSUP: begin
        if (supply_ok_i) begin
          st_d = ST_RHOLD;
        end
      end
      default: begin
        if (tmr_zero_i) begin
          st_d = succ(st_q);
        end
      end
    endcase
  end

  assign tmr_ld_o  = (st_d != st_q) && (last_idx(st_d) != '0 ||
                     st_d inside {ST_RHOLD, ST_CSPRE, ST_CSHOLD, ST_CKSTAB,
                                  ST_NOP, ST_MRWAIT, ST_MRW, ST_MRR, ST_ZQ,
                                  ST_ZQWAIT});
  assign tmr_val_o = last_idx(st_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign st_o   = st_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/lpinit_chdrv.sv
module lpinit_chdrv #(
  parameter int CA_W = 4
) (
  input  logic            en_i,
  input  logic            cs_act_i,
  input  logic [CA_W-1:0] ca_val_i,
  input  logic            ck_run_i,
  input  logic            wck_run_i,
  output logic            cs_o,
  output logic [CA_W-1:0] ca_o,
  output logic            ck_en_o,
  output logic            wck_en_o,
  output logic            dq_oe_o
);
  assign cs_o     = en_i & cs_act_i;
  assign ca_o     = (en_i && cs_act_i) ? ca_val_i : '0;
  assign ck_en_o  = en_i & ck_run_i;
  assign wck_en_o = en_i & wck_run_i;
  assign dq_oe_o  = 1'b0;
endmodule

// File: rtl/lpinit_seq.sv
module lpinit_seq
  import lpinit_pkg::*;
#(
  parameter int              MAX_CH        = 2,
  parameter int              CA_W          = 4,
  parameter longint unsigned CLK_PERIOD_PS = 5000,
  parameter longint unsigned T_RST_PS      = 200_000_000,
  parameter longint unsigned T_CSPRE_PS    = 10_000,
  parameter longint unsigned T_CSHOLD_PS   = 64'd4_000_000_000,
  parameter longint unsigned CK_STABLE_CYC = 5,
  parameter longint unsigned T_MRWAIT_PS   = 2_000_000,
  parameter longint unsigned T_ZQ_PS       = 30_000,
  parameter longint unsigned ZQ_MIN_CK     = 4,
  parameter longint unsigned CMD_CYC       = 2,
  parameter logic [CA_W-1:0] CA_NOP        = 4'h1,
  parameter logic [CA_W-1:0] CA_MRW        = 4'h2,
  parameter logic [CA_W-1:0] CA_MRR        = 4'h3,
  parameter logic [CA_W-1:0] CA_ZQ         = 4'h4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     supply_ok_i,
  input  logic [$clog2(MAX_CH+1)-1:0] ch_cnt_i,
  output logic                     mem_reset_n_o,
  output logic [MAX_CH-1:0]        cs_o,
  output logic [MAX_CH*CA_W-1:0]   ca_o,
  output logic [MAX_CH-1:0]        ck_en_o,
  output logic [MAX_CH-1:0]        wck_en_o,
  output logic [MAX_CH-1:0]        dq_oe_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     err_o
);
  localparam int CW = $clog2(MAX_CH + 1);

  localparam longint unsigned N_RST    = ps2cyc(T_RST_PS, CLK_PERIOD_PS);
  localparam longint unsigned N_CSPRE  = ps2cyc(T_CSPRE_PS, CLK_PERIOD_PS);
  localparam longint unsigned N_CSHOLD = ps2cyc(T_CSHOLD_PS, CLK_PERIOD_PS);
  localparam longint unsigned N_CKSTAB = max64(CK_STABLE_CYC, 64'd1);
  localparam longint unsigned N_MRWAIT = ps2cyc(T_MRWAIT_PS, CLK_PERIOD_PS);
  localparam longint unsigned N_ZQWAIT = max64(ps2cyc(T_ZQ_PS, CLK_PERIOD_PS),
                                               max64(ZQ_MIN_CK, 64'd1));
  localparam longint unsigned N_CMD    = max64(CMD_CYC, 64'd1) + 64'd1;
  localparam longint unsigned N_MAX    =
    max64(max64(max64(N_RST, N_CSPRE), max64(N_CSHOLD, N_CKSTAB)),
          max64(max64(N_MRWAIT, N_ZQWAIT), N_CMD));
  localparam int TW = $clog2(N_MAX + 1);

  logic          rst_sync_n;
  seq_st_e       st;
  logic          tmr_ld;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;
  logic [MAX_CH-1:0] mask;

  logic            rst_lvl;
  logic            ck_run;
  logic            wck_run;
  logic            cs_act;
  logic [CA_W-1:0] ca_val;

  lpinit_rstsync u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lpinit_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ld_i     (tmr_ld),
    .ld_val_i (tmr_val),
    .zero_o   (tmr_zero)
  );

  lpinit_fsm #(
    .TW       (TW),
    .MAX_CH   (MAX_CH),
    .CW       (CW),
    .D_RST    (TW'(N_RST - 1)),
    .D_CSPRE  (TW'(N_CSPRE - 1)),
    .D_CSHOLD (TW'(N_CSHOLD - 1)),
    .D_CKSTAB (TW'(N_CKSTAB - 1)),
    .D_MRWAIT (TW'(N_MRWAIT - 1)),
    .D_ZQWAIT (TW'(N_ZQWAIT - 1)),
    .D_CMD    (TW'(N_CMD - 1))
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_i     (start_i),
    .supply_ok_i (supply_ok_i),
    .ch_cnt_i    (ch_cnt_i),
    .tmr_zero_i  (tmr_zero),
    .st_o        (st),
    .tmr_ld_o    (tmr_ld),
    .tmr_val_o   (tmr_val),
    .mask_o      (mask)
  );

  // Phase decode: the last cycle of every command phase is a CS-low gap.
  always_comb begin
    rst_lvl = st inside {ST_CSHOLD, ST_CKSTAB, ST_NOP, ST_MRWAIT, ST_MRW,
                         ST_MRR, ST_ZQ, ST_ZQWAIT, ST_DONE};
    ck_run  = rst_lvl;
    wck_run = (st == ST_DONE);
    cs_act  = (st inside {ST_NOP, ST_MRW, ST_MRR, ST_ZQ}) && !tmr_zero;
    case (st)
      ST_NOP:  ca_val = CA_NOP;
      ST_MRW:  ca_val = CA_MRW;
      ST_MRR:  ca_val = CA_MRR;
      ST_ZQ:   ca_val = CA_ZQ;
      default: ca_val = '0;
    endcase
  end

  for (genvar g = 0; g < MAX_CH; g++) begin : g_ch
    lpinit_chdrv #(.CA_W(CA_W)) u_drv (
      .en_i      (mask[g]),
      .cs_act_i  (cs_act),
      .ca_val_i  (ca_val),
      .ck_run_i  (ck_run),
      .wck_run_i (wck_run),
      .cs_o      (cs_o[g]),
      .ca_o      (ca_o[g*CA_W +: CA_W]),
      .ck_en_o   (ck_en_o[g]),
      .wck_en_o  (wck_en_o[g]),
      .dq_oe_o   (dq_oe_o[g])
    );
  end

  assign mem_reset_n_o = rst_lvl;
  assign busy_o        = !(st inside {ST_IDLE, ST_DONE, ST_ERR});
  assign done_o        = (st == ST_DONE);
  assign err_o         = (st == ST_ERR);
endmodule

// File: rtl/lpinit_chk.sv
module lpinit_chk
  import lpinit_pkg::*;
#(
  parameter int              MAX_CH        = 2,
  parameter int              CA_W          = 4,
  parameter longint unsigned CLK_PERIOD_PS = 5000,
  parameter longint unsigned T_CSHOLD_PS   = 64'd4_000_000_000,
  parameter longint unsigned CK_STABLE_CYC = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   mem_reset_n_o,
  input logic [MAX_CH-1:0]      cs_o,
  input logic [MAX_CH*CA_W-1:0] ca_o,
  input logic [MAX_CH-1:0]      ck_en_o,
  input logic [MAX_CH-1:0]      wck_en_o,
  input logic [MAX_CH-1:0]      dq_oe_o,
  input logic                   busy_o,
  input logic                   done_o,
  input logic                   err_o
);
  localparam longint unsigned HOLD_MIN =
    ps2cyc(T_CSHOLD_PS, CLK_PERIOD_PS) + max64(CK_STABLE_CYC, 64'd1);

  logic [63:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (!mem_reset_n_o) begin
      hold_q <= '0;
    end else if (hold_q < HOLD_MIN) begin
      hold_q <= hold_q + 64'd1;
    end
  end

  AST_CS_LOW_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_reset_n_o) |-> $past(cs_o) == '0); // R3
  AST_CK_WITH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_reset_n_o) |-> ck_en_o[0]); // R3
  AST_CS_HOLD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_o != '0) |-> (hold_q >= HOLD_MIN)); // R4
  AST_CS_NEEDS_CK: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_o != '0) |-> ((cs_o & ~ck_en_o) == '0) && mem_reset_n_o); // R4
  AST_WCK_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wck_en_o != '0) |-> done_o); // R7
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy_o, done_o, err_o})); // R11
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !mem_reset_n_o && (cs_o == '0) && (ck_en_o == '0)); // R9
  AST_DQ_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (dq_oe_o == '0)); // R12

  for (genvar g = 1; g < MAX_CH; g++) begin : g_lock
    AST_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
      cs_o[g] |-> cs_o[0] && (ca_o[g*CA_W +: CA_W] == ca_o[CA_W-1:0])); // R8
  end
endmodule

bind lpinit_seq lpinit_chk #(
  .MAX_CH        (MAX_CH),
  .CA_W          (CA_W),
  .CLK_PERIOD_PS (CLK_PERIOD_PS),
  .T_CSHOLD_PS   (T_CSHOLD_PS),
  .CK_STABLE_CYC (CK_STABLE_CYC)
) u_chk (.*);

// File: tb/tb_lpinit_seq.sv
`timescale 1ns/1ps
module tb_lpinit_seq;
  localparam int CLK_PS = 5000;
  localparam int T_RST = 40000, T_CSPRE = 10000, T_CSHOLD = 30000;
  localparam int T_MRW = 12000, T_ZQ = 12000, ZQ_MIN = 4, CKSTAB = 5, CMD = 2;

  // Expected window lengths, derived from the requirements.
  localparam int N1 = (T_RST + CLK_PS - 1) / CLK_PS;
  localparam int N2 = (T_CSPRE + CLK_PS - 1) / CLK_PS;
  localparam int N3 = (T_CSHOLD + CLK_PS - 1) / CLK_PS;
  localparam int N5 = (T_MRW + CLK_PS - 1) / CLK_PS;
  localparam int NZR = (T_ZQ + CLK_PS - 1) / CLK_PS;
  localparam int NZ = (NZR > ZQ_MIN) ? NZR : ZQ_MIN;
  localparam int KB = N1 + N2;
  localparam int KD = KB + N3 + CKSTAB;
  localparam int KE = KD + CMD + 1;
  localparam int KF = KE + N5;
  localparam int KG = KF + 3 * (CMD + 1);
  localparam int KH = KG + NZ;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic       supply_ok_i;
  logic [1:0] ch_cnt_i;
  logic       mem_reset_n_o;
  logic [1:0] cs_o, ck_en_o, wck_en_o, dq_oe_o;
  logic [7:0] ca_o;
  logic       busy_o, done_o, err_o;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;

  // Behavioural model: mode 0 idle, 1 wait supply, 2 running, 3 done, 4 error
  int         m_mode = 0;
  int         m_k = 0;
  logic [1:0] m_mask = 2'b00;

  always #2.5 clk = ~clk;

  lpinit_seq #(
    .CLK_PERIOD_PS (CLK_PS),
    .T_RST_PS      (T_RST),
    .T_CSPRE_PS    (T_CSPRE),
    .T_CSHOLD_PS   (T_CSHOLD),
    .CK_STABLE_CYC (CKSTAB),
    .T_MRWAIT_PS   (T_MRW),
    .T_ZQ_PS       (T_ZQ),
    .ZQ_MIN_CK     (ZQ_MIN),
    .CMD_CYC       (CMD)
  ) dut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i),
    .supply_ok_i (supply_ok_i), .ch_cnt_i (ch_cnt_i),
    .mem_reset_n_o (mem_reset_n_o), .cs_o (cs_o), .ca_o (ca_o),
    .ck_en_o (ck_en_o), .wck_en_o (wck_en_o), .dq_oe_o (dq_oe_o),
    .busy_o (busy_o), .done_o (done_o), .err_o (err_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h",
               tag, what, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  // Model update on each edge from inputs that are stable since the negedge.
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_mode = 0;
      m_mask = 2'b00;
    end else if (m_mode == 0 || m_mode == 3 || m_mode == 4) begin
      if (start_i) begin
        if (ch_cnt_i == 2'd1 || ch_cnt_i == 2'd2) begin
          m_mode = 1;
          m_mask = (ch_cnt_i == 2'd2) ? 2'b11 : 2'b01;
        end else begin
          m_mode = 4;
        end
      end
    end else if (m_mode == 1) begin
      if (supply_ok_i) begin
        m_mode = 2;
        m_k = 0;
      end
    end else begin
      m_k++;
      if (m_k == KH) m_mode = 3;
    end
    if (cyc > 20000) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // Compare every output against the model on the falling edge.
  always @(negedge clk) begin
    logic       e_rst, e_ck, e_cs, e_wck, e_busy, e_done, e_err;
    logic [3:0] e_ca;
    logic [7:0] e_ca_v;
    string      tag;
    int         off;
    e_rst = 0; e_ck = 0; e_cs = 0; e_wck = 0; e_ca = 4'h0;
    e_busy = 0; e_done = 0; e_err = 0; tag = "R1";
    case (m_mode)
      1: begin e_busy = 1; tag = "R2"; end
      2: begin
        e_busy = 1;
        e_rst  = (m_k >= KB);
        e_ck   = e_rst;
        if (m_k < KB) tag = "R3";
        else if (m_k < KD) tag = "R4";
        else if (m_k < KE) begin
          tag = "R5"; off = m_k - KD;
          if (off < CMD) begin e_cs = 1; e_ca = 4'h1; end
        end else if (m_k < KG) begin
          tag = "R6";
          if (m_k >= KF) begin
            off = (m_k - KF) % (CMD + 1);
            if (off < CMD) begin
              e_cs = 1;
              e_ca = 4'h2 + 4'((m_k - KF) / (CMD + 1));
            end
          end
        end else tag = "R7";
      end
      3: begin e_rst = 1; e_ck = 1; e_wck = 1; e_done = 1; tag = "R11"; end
      4: begin e_err = 1; tag = "R9"; end
      default: ;
    endcase
    e_ca_v = {(m_mask[1] ? e_ca : 4'h0), (m_mask[0] ? e_ca : 4'h0)};
    chk(tag, "mem_reset_n", 32'(mem_reset_n_o), 32'(e_rst));
    chk(tag, "busy", 32'(busy_o), 32'(e_busy));
    chk(tag, "done", 32'(done_o), 32'(e_done));
    chk(tag, "err", 32'(err_o), 32'(e_err));
    chk(tag, "cs0", 32'(cs_o[0]), 32'(e_cs & m_mask[0]));
    chk(tag, "ca0", 32'(ca_o[3:0]), 32'(e_ca_v[3:0]));
    chk(tag, "ck0", 32'(ck_en_o[0]), 32'(e_ck & m_mask[0]));
    chk(tag, "wck0", 32'(wck_en_o[0]), 32'(e_wck & m_mask[0]));
    // R8: sub-channel 1 follows channel 0 only when two are selected
    chk("R8", "cs1", 32'(cs_o[1]), 32'(e_cs & m_mask[1]));
    chk("R8", "ca1", 32'(ca_o[7:4]), 32'(e_ca_v[7:4]));
    chk("R8", "ck1", 32'(ck_en_o[1]), 32'(e_ck & m_mask[1]));
    chk("R8", "wck1", 32'(wck_en_o[1]), 32'(e_wck & m_mask[1]));
    chk("R12", "dq_oe", 32'(dq_oe_o), 32'd0);
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start(input logic [1:0] cnt);
    @(negedge clk);
    start_i  = 1'b1;
    ch_cnt_i = cnt;
    @(negedge clk);
    start_i  = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; supply_ok_i = 1'b0; ch_cnt_i = 2'd0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    // R1: reset state seen directly
    chk("R1", "reset outputs", {mem_reset_n_o, cs_o, ck_en_o, busy_o, done_o},
        32'd0);

    // One sub-channel, late supply
    pulse_start(2'd1);
    wait_cyc(5);
    chk("R2", "reset low while waiting for supply", 32'(mem_reset_n_o), 32'd0);
    supply_ok_i = 1'b1;
    wait_cyc(KD);
    // R10: start with a two-channel count while busy must be ignored
    pulse_start(2'd2);
    chk("R10", "busy kept after ignored start", 32'(busy_o), 32'd1);
    chk("R10", "sub-channel 1 stays idle", 32'(ck_en_o[1]), 32'd0);
    wait_cyc(KH);
    chk("R7", "done after one-channel run", 32'(done_o), 32'd1);
    wait_cyc(10);
    chk("R11", "done still set", 32'(done_o), 32'd1);

    // Invalid counts
    pulse_start(2'd3);
    wait_cyc(3);
    chk("R9", "err on count 3", 32'(err_o), 32'd1);
    pulse_start(2'd0);
    wait_cyc(6);
    chk("R9", "err on count 0 held", 32'(err_o), 32'd1);

    // Two sub-channels, supply already good
    pulse_start(2'd2);
    wait_cyc(2);
    chk("R9", "err cleared by valid start", 32'(err_o), 32'd0);
    wait_cyc(KH + 4);
    chk("R8", "both WCK enables at done", 32'(wck_en_o), 32'd3);
    wait_cyc(5);
    finish_run();
  end
endmodule